// File: doc/BRIEF.md
# Multi-user inter-processor mailbox

This block is a memory-mapped message exchange shared by several processors. It holds a set of small hardware queues, each 32 bits wide. A processor posts a word by writing the message address of a queue. A processor takes the oldest word by reading that same address, and the read removes the word. For every queue there is also a full flag and a count of the words held. Software decides which processor sends and which receives on each queue.

Every processor on the bus is a "user" with its own event status register, its own interrupt mask and its own interrupt line. A queue raises a new-message event when a word is accepted. It raises a space-available event when it leaves the full state. Both events are latched in all users at once. Each user chooses which events reach its line through write-1-to-set and write-1-to-clear mask addresses, and acknowledges events by writing 1s to its status. Access is through a simple synchronous bus. Read data is combinational in the cycle of the access, and pushes, pops and register updates take effect at the clock edge that ends it.

Top module: `ipc_mailbox`

## Requirements
- R1: A read of byte address 0x000 returns the constant given by parameter REV_VALUE.
- R2: A write to 0x040 + 4*m pushes the data into queue m. A read of that address returns the oldest word and removes it, so words leave in the order they were written.
- R3: A queue holds at most FIFO_DEPTH words, and a push to a full queue is dropped. Address 0x080 + 4*m reads 1 while queue m is full and 0 otherwise.
- R4: Address 0x0C0 + 4*m reads the number of words queue m currently holds. A value of 0 means the queue is empty.
- R5: A read of an empty queue's message address returns 0 and leaves its count at 0.
- R6: Status bit 2*m (new message) is set in the status register of every user when queue m accepts a word.
- R7: Status bit 2*m+1 (space available) is set in every user when queue m goes from full to not full.
- R8: For user u, the status register sits at 0x104 + 0x10*u. Writing a 1 to a status bit clears it and writing a 0 has no effect. A clear of bit 2*m while queue m still holds words leaves that bit set.
- R9: For user u, writing 1s to 0x108 + 0x10*u adds those bits to the interrupt mask, and writing 1s to 0x10C + 0x10*u removes them. Both addresses read back the current mask.
- R10: A status read returns the latched events whatever the mask holds. Output irq_o[u] is 1 exactly when the status and the mask of user u share a set bit.
- R11: Any address that is not decoded reads 0, and a write to it changes no queue, status or mask.
- R12: After reset every queue is empty, every status and mask is 0, and every interrupt line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during a read access |
| irq_o | output | NUM_USERS | Per-user interrupt, level high |

## Verification
The bench builds the block with four queues of depth four, two users and a non-default revision constant. With depth four, the full state, the dropped fifth push and the full-to-not-full event all come up within a few bus accesses. Two users let the bench show that one event lands in both status registers while only the user whose mask allows it raises its line. Four queues leave message addresses above the last queue that are legal in the map but not decoded, and the bench uses them for the ignored-write checks.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;

  localparam int ADDR_W = 9;

  typedef enum logic [2:0] {
    ACC_NONE, ACC_REV, ACC_MSG, ACC_FULL, ACC_CNT, ACC_STAT, ACC_ENSET, ACC_ENCLR
  } acc_kind_e;

  typedef struct packed {
    acc_kind_e  kind;
    logic [7:0] idx;
  } acc_t;

  // Map a byte address to a register kind and a queue or user index.
  function automatic acc_t decode_addr(input logic [ADDR_W-1:0] addr,
                                       input int nf, input int nu);
    acc_t a;
    int   w;
    int   rel;
    a.kind = ACC_NONE;
    a.idx  = '0;
    if (addr[1:0] == 2'b00) begin
      if (addr == '0) begin
        a.kind = ACC_REV;
      end else if (addr >= 9'h040 && addr < 9'h100) begin
        w = int'(addr[5:2]);
        if (w < nf) begin
          a.idx = 8'(w);
          case (addr[7:6])
            2'b01:   a.kind = ACC_MSG;
            2'b10:   a.kind = ACC_FULL;
            2'b11:   a.kind = ACC_CNT;
            default: a.kind = ACC_NONE;
          endcase
        end
      end else if (addr >= 9'h104) begin
        rel = int'(addr) - 32'h104;
        w   = rel >> 4;
        if (w < nu) begin
          a.idx = 8'(w);
          case ((rel >> 2) & 3)
            0:       a.kind = ACC_STAT;
            1:       a.kind = ACC_ENSET;
            2:       a.kind = ACC_ENCLR;
            default: a.kind = ACC_NONE;
          endcase
        end
      end
    end
    return a;
  endfunction

  function automatic int newmsg_bit(input int m);
    return 2 * m;
  endfunction

  function automatic int space_bit(input int m);
    return 2 * m + 1;
  endfunction

endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] head_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              push_evt_o,
  output logic              space_evt_o
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count_q;
  logic              do_push, do_pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o      = (count_q == CNT_W'(DEPTH));
  assign empty_o     = (count_q == '0);
  assign do_push     = push_i && !full_o;
  assign do_pop      = pop_i && !empty_o;
  assign push_evt_o  = do_push;
  assign space_evt_o = do_pop && full_o;
  assign head_o      = empty_o ? '0 : mem[rd_ptr];
  assign count_o     = count_q;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      if (do_push && !do_pop)      count_q <= count_q + 1'b1;
      else if (do_pop && !do_push) count_q <= count_q - 1'b1;
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH));

  assert_full_push_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && push_i && !pop_i) |=> (count_q == CNT_W'(DEPTH)));

  assert_empty_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && pop_i && !push_i) |=> (count_q == '0));

endmodule

// File: rtl/mbox_user_irq.sv
module mbox_user_irq #(
  parameter int NBITS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] ev_i,
  input  logic [NBITS-1:0] hold_i,
  input  logic [NBITS-1:0] stat_clr_i,
  input  logic [NBITS-1:0] en_set_i,
  input  logic [NBITS-1:0] en_clr_i,
  output logic [NBITS-1:0] status_o,
  output logic [NBITS-1:0] enable_o,
  output logic             irq_o
);

  logic [NBITS-1:0] status_q, enable_q;
  logic [NBITS-1:0] clr_effective;

  // A clear of a new-message bit while its queue holds words is refused.
  assign clr_effective = stat_clr_i & ~hold_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
      irq_o    <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr_effective) | ev_i | (stat_clr_i & hold_i);
      enable_q <= (enable_q | en_set_i) & ~en_clr_i;
      irq_o    <= |((((status_q & ~clr_effective) | ev_i | (stat_clr_i & hold_i)))
                    & ((enable_q | en_set_i) & ~en_clr_i));
    end
  end

  assign status_o = status_q;
  assign enable_o = enable_q;

  assert_event_latched_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_i) |=> ((status_o & $past(ev_i)) == $past(ev_i)));

  assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat_clr_i & ~ev_i & ~hold_i)) |=>
      ((status_o & $past(stat_clr_i & ~ev_i & ~hold_i)) == '0));

  assert_mask_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|en_clr_i) |=> ((enable_o & $past(en_clr_i)) == '0));

  assert_irq_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_o & enable_o) == '0) |-> !irq_o);

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_mbox_pkg::*;
#(
  parameter int          NUM_FIFOS  = 8,
  parameter int          NUM_USERS  = 4,
  parameter int          FIFO_DEPTH = 4,
  parameter logic [31:0] REV_VALUE  = 32'h0000_0100
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [8:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [NUM_USERS-1:0] irq_o
);

  localparam int NBITS = 2 * NUM_FIFOS;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  acc_t acc;
  logic wr_acc, rd_acc;

  assign acc    = decode_addr(bus_addr, NUM_FIFOS, NUM_USERS);
  assign wr_acc = bus_sel && bus_wr;
  assign rd_acc = bus_sel && !bus_wr;

  // Named internal events for checking.
  logic [31:0]      head   [NUM_FIFOS];
  logic [CNT_W-1:0] count  [NUM_FIFOS];
  logic [NUM_FIFOS-1:0] full_v, empty_v, push_evt, space_evt;
  logic [NBITS-1:0] ev_vec, hold_vec;
  logic [NUM_FIFOS*CNT_W-1:0] count_flat;

  genvar f;
  generate
    for (f = 0; f < NUM_FIFOS; f++) begin : g_fifo
      logic push_f, pop_f;
      assign push_f = wr_acc && acc.kind == ACC_MSG && acc.idx == 8'(f);
      assign pop_f  = rd_acc && acc.kind == ACC_MSG && acc.idx == 8'(f);

      mbox_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(32)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (push_f),
        .pop_i      (pop_f),
        .wdata_i    (bus_wdata),
        .head_o     (head[f]),
        .count_o    (count[f]),
        .full_o     (full_v[f]),
        .empty_o    (empty_v[f]),
        .push_evt_o (push_evt[f]),
        .space_evt_o(space_evt[f])
      );

      assign ev_vec[newmsg_bit(f)]   = push_evt[f];
      assign ev_vec[space_bit(f)]    = space_evt[f];
      assign hold_vec[newmsg_bit(f)] = !empty_v[f];
      assign hold_vec[space_bit(f)]  = 1'b0;
      assign count_flat[f*CNT_W +: CNT_W] = count[f];
    end
  endgenerate

  logic [NBITS-1:0] status [NUM_USERS];
  logic [NBITS-1:0] enable [NUM_USERS];

  genvar u;
  generate
    for (u = 0; u < NUM_USERS; u++) begin : g_user
      logic sel_u;
      logic [NBITS-1:0] clr_u, set_u, dis_u;
      assign sel_u = wr_acc && acc.idx == 8'(u);
      assign clr_u = (sel_u && acc.kind == ACC_STAT)  ? bus_wdata[NBITS-1:0] : '0;
      assign set_u = (sel_u && acc.kind == ACC_ENSET) ? bus_wdata[NBITS-1:0] : '0;
      assign dis_u = (sel_u && acc.kind == ACC_ENCLR) ? bus_wdata[NBITS-1:0] : '0;

      mbox_user_irq #(.NBITS(NBITS)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_i      (ev_vec),
        .hold_i    (hold_vec),
        .stat_clr_i(clr_u),
        .en_set_i  (set_u),
        .en_clr_i  (dis_u),
        .status_o  (status[u]),
        .enable_o  (enable[u]),
        .irq_o     (irq_o[u])
      );
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    if (rd_acc) begin
      case (acc.kind)
        ACC_REV:   bus_rdata = REV_VALUE;
        ACC_MSG:   bus_rdata = head[acc.idx];
        ACC_FULL:  bus_rdata = {31'b0, full_v[acc.idx]};
        ACC_CNT:   bus_rdata = 32'(count[acc.idx]);
        ACC_STAT:  bus_rdata = 32'(status[acc.idx]);
        ACC_ENSET,
        ACC_ENCLR: bus_rdata = 32'(enable[acc.idx]);
        default:   bus_rdata = '0;
      endcase
    end
  end

  assert_undecoded_write_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && acc.kind == ACC_NONE) |=> $stable(count_flat));

  assert_single_event_kind_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({|push_evt, |space_evt}));

endmodule

// File: tb/ipc_mailbox_tb.sv
module ipc_mailbox_tb;

  localparam int NF = 4;
  localparam int NU = 2;
  localparam int DP = 4;
  localparam logic [31:0] REV = 32'hA5C3_0102;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NU-1:0] irq_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  ipc_mailbox #(.NUM_FIFOS(NF), .NUM_USERS(NU), .FIFO_DEPTH(DP), .REV_VALUE(REV)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  function automatic logic [8:0] a_msg(int m);  return 9'(32'h040 + 4 * m); endfunction
  function automatic logic [8:0] a_full(int m); return 9'(32'h080 + 4 * m); endfunction
  function automatic logic [8:0] a_cnt(int m);  return 9'(32'h0C0 + 4 * m); endfunction
  function automatic logic [8:0] a_stat(int u); return 9'(32'h104 + 16 * u); endfunction
  function automatic logic [8:0] a_eset(int u); return 9'(32'h108 + 16 * u); endfunction
  function automatic logic [8:0] a_eclr(int u); return 9'(32'h10C + 16 * u); endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk);
    #1 bus_sel = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [8:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic clear_all();
    for (int u = 0; u < NU; u++) wr(a_stat(u), 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    for (int u = 0; u < NU; u++) begin
      rd_chk("R12 status after reset", a_stat(u), 0);
      rd_chk("R12 mask after reset", a_eset(u), 0);
    end
    for (int m = 0; m < NF; m++) rd_chk("R12 count after reset", a_cnt(m), 0);
    chk("R12 irq after reset", 32'(irq_o), 0);
  endtask

  task automatic t_revision();
    rd_chk("R1 revision", 9'h000, REV);
  endtask

  task automatic t_order();
    wr(a_msg(1), 32'h1111_0001);
    wr(a_msg(1), 32'h2222_0002);
    wr(a_msg(1), 32'h3333_0003);
    rd_chk("R4 count three", a_cnt(1), 3);
    rd_chk("R3 not full", a_full(1), 0);
    rd_chk("R2 first", a_msg(1), 32'h1111_0001);
    rd_chk("R2 second", a_msg(1), 32'h2222_0002);
    rd_chk("R4 count one", a_cnt(1), 1);
    rd_chk("R2 third", a_msg(1), 32'h3333_0003);
    rd_chk("R4 count zero", a_cnt(1), 0);
    clear_all();
  endtask

  task automatic t_full();
    for (int i = 0; i < DP + 1; i++) wr(a_msg(2), 32'hC0DE_0000 + i);
    rd_chk("R3 full flag", a_full(2), 1);
    rd_chk("R3 count at depth", a_cnt(2), DP);
    for (int i = 0; i < DP; i++) begin
      rd_chk("R3 stored word", a_msg(2), 32'hC0DE_0000 + i);
      if (i == 0) rd_chk("R3 full flag drops", a_full(2), 0);
    end
    rd_chk("R3 fifth push dropped", a_cnt(2), 0);
    clear_all();
  endtask

  task automatic t_empty_pop();
    rd_chk("R5 empty read zero", a_msg(0), 0);
    rd_chk("R5 count stays zero", a_cnt(0), 0);
    wr(a_msg(0), 32'h0000_BEEF);
    rd_chk("R5 later push unaffected", a_msg(0), 32'h0000_BEEF);
    clear_all();
  endtask

  task automatic t_status();
    wr(a_msg(3), 32'h5A5A_5A5A);
    rd_chk("R6 user0 new message bit 6", a_stat(0), 32'h40);
    rd_chk("R6 user1 new message bit 6", a_stat(1), 32'h40);
    wr(a_stat(0), 32'h0);
    rd_chk("R8 write zero no effect", a_stat(0), 32'h40);
    wr(a_stat(0), 32'h40);
    rd_chk("R8 clear refused while non-empty", a_stat(0), 32'h40);
    rd_chk("R8 drain", a_msg(3), 32'h5A5A_5A5A);
    wr(a_stat(0), 32'h40);
    rd_chk("R8 clear after drain", a_stat(0), 0);
    rd_chk("R8 other user untouched", a_stat(1), 32'h40);
    clear_all();
  endtask

  task automatic t_space();
    for (int i = 0; i < DP; i++) wr(a_msg(0), 32'h100 + i);
    wr(a_stat(0), 32'h2);
    rd_chk("R7 no space event yet", a_stat(0), 32'h1);
    rd_chk("R7 pop from full", a_msg(0), 32'h100);
    rd_chk("R7 user0 space bit 1", a_stat(0), 32'h3);
    rd_chk("R7 user1 space bit 1", a_stat(1), 32'h3);
    wr(a_stat(1), 32'h2);
    rd_chk("R7 second pop not from full", a_msg(0), 32'h101);
    rd_chk("R7 no new space event", a_stat(1), 32'h1);
    for (int i = 2; i < DP; i++) rd_chk("R2 drain", a_msg(0), 32'h100 + i);
    clear_all();
  endtask

  task automatic t_mask();
    wr(a_eset(1), 32'h5);
    rd_chk("R9 set readback", a_eset(1), 32'h5);
    rd_chk("R9 clear address readback", a_eclr(1), 32'h5);
    wr(a_eclr(1), 32'h1);
    rd_chk("R9 after clear", a_eset(1), 32'h4);
    rd_chk("R9 user0 mask untouched", a_eset(0), 0);
    chk("R10 irq low idle", 32'(irq_o), 0);
    wr(a_msg(1), 32'h77);
    chk("R10 irq user1 high", 32'(irq_o[1]), 1);
    chk("R10 irq user0 masked", 32'(irq_o[0]), 0);
    rd_chk("R10 raw status user0", a_stat(0), 32'h4);
    rd_chk("R2 pop", a_msg(1), 32'h77);
    wr(a_stat(1), 32'h4);
    chk("R10 irq user1 low after ack", 32'(irq_o[1]), 0);
    wr(a_eclr(1), 32'hFFFF);
    clear_all();
  endtask

  task automatic t_undecoded();
    wr(a_msg(NF), 32'hDEAD);
    wr(9'h004, 32'hFFFF);
    wr(9'h100, 32'hFFFF);
    wr(9'h110, 32'hFFFF);
    wr(9'h1F0, 32'hFFFF);
    for (int m = 0; m < NF; m++) rd_chk("R11 counts unchanged", a_cnt(m), 0);
    for (int u = 0; u < NU; u++) begin
      rd_chk("R11 status unchanged", a_stat(u), 0);
      rd_chk("R11 mask unchanged", a_eset(u), 0);
    end
    rd_chk("R11 read beyond queues", a_msg(NF), 0);
    rd_chk("R11 read 0x004", 9'h004, 0);
    rd_chk("R11 read 0x110", 9'h110, 0);
    rd_chk("R11 read 0x1F0", 9'h1F0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_revision();
    t_order();
    t_full();
    t_empty_pop();
    t_status();
    t_space();
    t_mask();
    t_undecoded();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule